// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address by walking a radix tree of 64-bit page table entries held in memory. A request carries the virtual address, the kind of access (load, store or instruction fetch), the current privilege level, and two status bits. The first status bit lets supervisor code touch user pages. The second lets loads read from execute-only pages. The walker reads one entry per level through a single-outstanding memory port. At each entry it decides whether to descend, stop on a leaf, or fault.

On a good leaf the walker works out the new entry value. The accessed flag is always set, and the dirty flag is also set for stores. When this value differs from the one read, the walker writes it back with a compare-and-swap. If another agent changed the entry in the meantime, the swap misses and the whole walk starts again from the root. If the entry sits in memory that cannot be updated, the walk faults. The result is a one-cycle completion pulse. It carries either a fault or a physical address with read, write and execute permissions.

Leaves may appear at any of the three levels, which gives 4 KiB, 2 MiB and 1 GiB pages.

Top module: `pt_walker`

## Requirements
- R1: After reset, and whenever idle, `req_ready` is 1, `mem_req_valid` is 0 and `done` is 0.
- R2: The walk begins at the root table `root_ppn` using VA bits [38:30]. The entry address is the table base (PPN << 12) plus slice × 8. The entry's PPN is bits [53:10]. Flag bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7. A valid entry with R, W and X all clear points to the next table, indexed by VA bits [29:21] and then [20:12].
- R3: An entry with V clear faults. A pointer found at the last level faults.
- R4: A leaf whose R is clear while W is set (W alone, or W with X) faults.
- R5: A leaf with U set faults in supervisor mode (`req_priv_s`=1) unless `req_sum` is 1 and the access is not a fetch. It is allowed in user mode.
- R6: A leaf with U clear faults in user mode.
- R7: A leaf at level L (L levels above the last) must have its low 9·L PPN bits zero, or the walk faults. The PA is (PPN | low 9·L VPN bits) << 12 | VA[11:0].
- R8: Access codes are 0 load, 1 store, 2 fetch and 3 reserved. A load needs R, or X with `req_mxr`=1. A store needs W. A fetch needs X. Code 3 always faults.
- R9: On success `done_r` = R | (X & mxr), `done_x` = X, and `done_w` = W & (store | D). On a fault, all three and `done_pa` are 0.
- R10: A successful leaf writes back entry | A, plus D for stores. This happens by compare-and-swap (`mem_req_cas`=1, compare = value read), and only if the value changes.
- R11: A compare-and-swap whose returned old value differs from the compare value restarts the walk with a read of the root entry.
- R12: If a write-back is needed and the entry's read response flagged `mem_rsp_ro`, the walk faults and no swap is issued.
- R13: `done` lasts one cycle. A memory request holds `mem_req_valid` and its fields stable until `mem_req_ready`, and at most one memory operation is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 39 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| req_priv_s | input | 1 | 1 supervisor, 0 user |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| root_ppn | input | 44 | Page number of the root table |
| mem_req_valid | output | 1 | Memory operation request |
| mem_req_ready | input | 1 | Memory accepts the operation |
| mem_req_cas | output | 1 | 0 read, 1 compare-and-swap |
| mem_req_addr | output | 56 | Entry byte address |
| mem_req_cmp | output | 64 | Compare value for swap |
| mem_req_swap | output | 64 | New value for swap |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_data | input | 64 | Read data, or old value for a swap |
| mem_rsp_ro | input | 1 | Entry location cannot be updated |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk faulted |
| done_pa | output | 56 | Physical address |
| done_r | output | 1 | Read permitted |
| done_w | output | 1 | Write permitted |
| done_x | output | 1 | Execute permitted |

## Verification
The hardest case to reach from the ports is a lost compare-and-swap race. Another agent has to alter the entry after the walker read it but before its swap lands. The bench memory model has an arming switch for this. When armed, it flips a software-reserved bit of the target word on the first swap it receives, and it does so just before the compare. The swap therefore misses, and the bench then counts six reads and two swaps, and checks the final memory word. Non-updatable regions are reached by placing a table at an address the model flags read-only.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_REQ, ST_READ_WAIT, ST_CHECK, ST_CAS_REQ, ST_CAS_WAIT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2, ACC_RSVD = 2'd3
  } acc_e;

  // entry flag positions (entry format, decoded by the walker)
  localparam int unsigned FLG_V = 0;
  localparam int unsigned FLG_R = 1;
  localparam int unsigned FLG_W = 2;
  localparam int unsigned FLG_X = 3;
  localparam int unsigned FLG_U = 4;
  localparam int unsigned FLG_A = 6;
  localparam int unsigned FLG_D = 7;
endpackage

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  input  logic             priv_s,
  input  logic             sum,
  input  logic             mxr,
  output logic             is_invalid,
  output logic             is_pointer,
  output logic             is_reserved,
  output logic             priv_fail,
  output logic             access_fail,
  output logic             need_upd,
  output logic [PTE_W-1:0] pte_upd,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x
);
  logic f_v, f_r, f_w, f_x, f_u, f_d, is_store, is_fetch;

  function automatic logic [PTE_W-1:0] f_mark(input logic [PTE_W-1:0] e, input logic st);
    logic [PTE_W-1:0] m;
    m = '0;
    m[FLG_A] = 1'b1;
    m[FLG_D] = st;
    return e | m;
  endfunction

  assign f_v = pte[FLG_V];
  assign f_r = pte[FLG_R];
  assign f_w = pte[FLG_W];
  assign f_x = pte[FLG_X];
  assign f_u = pte[FLG_U];
  assign f_d = pte[FLG_D];
  assign is_store = (acc == ACC_STORE);
  assign is_fetch = (acc == ACC_FETCH);

  assign is_invalid  = ~f_v;
  assign is_pointer  = f_v & ~f_r & ~f_w & ~f_x;
  assign is_reserved = f_w & ~f_r;
  assign priv_fail   = f_u ? (priv_s & (~sum | is_fetch)) : ~priv_s;

  always_comb begin
    case (acc)
      ACC_LOAD:  access_fail = ~(f_r | (f_x & mxr));
      ACC_STORE: access_fail = ~f_w;
      ACC_FETCH: access_fail = ~f_x;
      default:   access_fail = 1'b1;
    endcase
  end

  assign pte_upd  = f_mark(pte, is_store);
  assign need_upd = (pte_upd != pte);
  assign perm_r   = f_r | (f_x & mxr);
  assign perm_w   = f_w & (is_store | f_d);
  assign perm_x   = f_x;
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int LEVELS  = 3,
  parameter int VPN_W   = 9,
  parameter int PGOFF_W = 12,
  parameter int PPN_W   = 44,
  parameter int PTE_W   = 64,
  parameter int VA_W    = 39,
  parameter int PA_W    = 56,
  parameter int LVL_W   = 2
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  input  logic [PPN_W-1:0] leaf_ppn,
  output logic [PA_W-1:0]  pte_addr,
  output logic [PA_W-1:0]  phys_addr,
  output logic             misaligned
);
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  logic [VPN_W-1:0] slice_tab [LEVELS];
  logic [PPN_W-1:0] mask_tab  [LEVELS];
  logic [VPN_W-1:0] slice_sel;
  logic [PPN_W-1:0] mask_sel;
  logic [PPN_W-1:0] vpn_ext;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign slice_tab[g] = va[PGOFF_W + g*VPN_W +: VPN_W];
    assign mask_tab[g]  = ~({PPN_W{1'b1}} << (g*VPN_W));
  end

  function automatic logic [PA_W-1:0] f_entry_addr(input logic [PPN_W-1:0] b,
                                                   input logic [VPN_W-1:0] s);
    return {b, {PGOFF_W{1'b0}}} + (PA_W'(s) << ENTRY_SHIFT);
  endfunction

  function automatic logic [PA_W-1:0] f_join_pa(input logic [PPN_W-1:0] p,
                                                input logic [PPN_W-1:0] v,
                                                input logic [PPN_W-1:0] m,
                                                input logic [PGOFF_W-1:0] off);
    return {p | (v & m), off};
  endfunction

  assign slice_sel  = slice_tab[level];
  assign mask_sel   = mask_tab[level];
  assign vpn_ext    = PPN_W'(va[VA_W-1:PGOFF_W]);
  assign pte_addr   = f_entry_addr(base_ppn, slice_sel);
  assign phys_addr  = f_join_pa(leaf_ppn, vpn_ext, mask_sel, va[PGOFF_W-1:0]);
  assign misaligned = |(leaf_ppn & mask_sel);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS  = 3,
  parameter int VPN_W   = 9,
  parameter int PGOFF_W = 12,
  parameter int PTE_W   = 64,
  parameter int PPN_LSB = 10,
  parameter int PPN_W   = 44,
  localparam int VA_W   = LEVELS * VPN_W + PGOFF_W,
  localparam int PA_W   = PPN_W + PGOFF_W,
  localparam int LVL_W  = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  input  logic             req_priv_s,
  input  logic             req_sum,
  input  logic             req_mxr,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_cas,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_cmp,
  output logic [PTE_W-1:0] mem_req_swap,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  input  logic             mem_rsp_ro,
  output logic             done,
  output logic             done_fault,
  output logic [PA_W-1:0]  done_pa,
  output logic             done_r,
  output logic             done_w,
  output logic             done_x
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_state_e      state;
  logic [LVL_W-1:0] level_q;
  logic [PPN_W-1:0] base_q, root_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             priv_q, sum_q, mxr_q;
  logic [PTE_W-1:0] pte_q;
  logic             pte_ro_q;

  logic [PPN_W-1:0] pte_ppn;
  logic [PA_W-1:0]  pte_addr, phys_addr;
  logic             misaligned;
  logic             is_invalid, is_pointer, is_reserved, priv_fail, access_fail, need_upd;
  logic [PTE_W-1:0] pte_upd;
  logic             perm_r, perm_w, perm_x;

  // named internal events
  logic in_check, leaf_fault, ev_descend, ev_walk_fault, ev_leaf_ok;
  logic ev_cas_start, ev_cas_hit, ev_cas_miss, fin_ok;

  assign pte_ppn = pte_q[PPN_LSB +: PPN_W];

  ptw_addr_gen #(
    .LEVELS(LEVELS), .VPN_W(VPN_W), .PGOFF_W(PGOFF_W), .PPN_W(PPN_W),
    .PTE_W(PTE_W), .VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W)
  ) u_addr (
    .base_ppn(base_q), .va(va_q), .level(level_q), .leaf_ppn(pte_ppn),
    .pte_addr(pte_addr), .phys_addr(phys_addr), .misaligned(misaligned)
  );

  ptw_leaf_check #(.PTE_W(PTE_W)) u_leaf (
    .pte(pte_q), .acc(acc_q), .priv_s(priv_q), .sum(sum_q), .mxr(mxr_q),
    .is_invalid(is_invalid), .is_pointer(is_pointer), .is_reserved(is_reserved),
    .priv_fail(priv_fail), .access_fail(access_fail), .need_upd(need_upd),
    .pte_upd(pte_upd), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  assign in_check      = (state == ST_CHECK);
  assign leaf_fault    = is_reserved | priv_fail | misaligned | access_fail;
  assign ev_descend    = in_check & is_pointer & (level_q != '0);
  assign ev_walk_fault = in_check & (is_invalid | (is_pointer & (level_q == '0)) |
                         (~is_invalid & ~is_pointer & (leaf_fault | (need_upd & pte_ro_q))));
  assign ev_leaf_ok    = in_check & ~is_invalid & ~is_pointer & ~leaf_fault;
  assign ev_cas_start  = ev_leaf_ok & need_upd & ~pte_ro_q;
  assign ev_cas_hit    = (state == ST_CAS_WAIT) & mem_rsp_valid & (mem_rsp_data == pte_q);
  assign ev_cas_miss   = (state == ST_CAS_WAIT) & mem_rsp_valid & (mem_rsp_data != pte_q);
  assign fin_ok        = (ev_leaf_ok & ~need_upd) | ev_cas_hit;

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_READ_REQ) | (state == ST_CAS_REQ);
  assign mem_req_cas   = (state == ST_CAS_REQ);
  assign mem_req_addr  = pte_addr;
  assign mem_req_cmp   = pte_q;
  assign mem_req_swap  = pte_upd;
  assign done          = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      level_q    <= '0;
      base_q     <= '0;
      root_q     <= '0;
      va_q       <= '0;
      acc_q      <= '0;
      priv_q     <= 1'b0;
      sum_q      <= 1'b0;
      mxr_q      <= 1'b0;
      pte_q      <= '0;
      pte_ro_q   <= 1'b0;
      done_fault <= 1'b0;
      done_pa    <= '0;
      done_r     <= 1'b0;
      done_w     <= 1'b0;
      done_x     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          acc_q   <= req_acc;
          priv_q  <= req_priv_s;
          sum_q   <= req_sum;
          mxr_q   <= req_mxr;
          root_q  <= root_ppn;
          base_q  <= root_ppn;
          level_q <= TOP_LVL;
          state   <= ST_READ_REQ;
        end
        ST_READ_REQ: if (mem_req_ready) state <= ST_READ_WAIT;
        ST_READ_WAIT: if (mem_rsp_valid) begin
          pte_q    <= mem_rsp_data;
          pte_ro_q <= mem_rsp_ro;
          state    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (ev_descend) begin
            base_q  <= pte_ppn;
            level_q <= level_q - 1'b1;
            state   <= ST_READ_REQ;
          end else if (ev_cas_start) begin
            state <= ST_CAS_REQ;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_CAS_REQ: if (mem_req_ready) state <= ST_CAS_WAIT;
        ST_CAS_WAIT: if (mem_rsp_valid) begin
          if (ev_cas_miss) begin
            base_q  <= root_q;
            level_q <= TOP_LVL;
            state   <= ST_READ_REQ;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase

      if (fin_ok) begin
        done_fault <= 1'b0;
        done_pa    <= phys_addr;
        done_r     <= perm_r;
        done_w     <= perm_w;
        done_x     <= perm_x;
      end else if (ev_walk_fault) begin
        done_fault <= 1'b1;
        done_pa    <= '0;
        done_r     <= 1'b0;
        done_w     <= 1'b0;
        done_x     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_cas,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [PTE_W-1:0] mem_req_cmp,
  input logic [PTE_W-1:0] mem_req_swap,
  input logic             done,
  input logic             done_fault,
  input logic             done_r,
  input logic             done_w,
  input logic             done_x,
  input logic             ev_cas_miss,
  input logic             pte_ro_q
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !done);

  p_entry_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

  p_fault_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> !(done_r || done_w || done_x));

  p_swap_marks_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_cas) |-> mem_req_swap[6] && (mem_req_swap != mem_req_cmp));

  p_restart_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cas_miss |=> mem_req_valid && !mem_req_cas);

  p_no_swap_ro_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid && mem_req_cas) |-> !pte_ro_q);

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_cas));
endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W), .PTE_W(PTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_cas(mem_req_cas), .mem_req_addr(mem_req_addr),
  .mem_req_cmp(mem_req_cmp), .mem_req_swap(mem_req_swap),
  .done(done), .done_fault(done_fault), .done_r(done_r), .done_w(done_w),
  .done_x(done_x), .ev_cas_miss(ev_cas_miss), .pte_ro_q(pte_ro_q)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [38:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_priv_s = 1'b1, req_sum = 1'b0, req_mxr = 1'b0;
  logic [43:0] root_ppn = 44'h100;
  logic        mem_req_valid, mem_req_cas;
  logic        mem_req_ready = 1'b0;
  logic [55:0] mem_req_addr;
  logic [63:0] mem_req_cmp, mem_req_swap;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_ro = 1'b0;
  logic        done, done_fault, done_r, done_w, done_x;
  logic [55:0] done_pa;

  int checks = 0, errors = 0;
  int rd_total = 0, cas_total = 0;

  logic [63:0] mem [logic [55:0]];
  logic        poke_en = 1'b0;
  logic [55:0] poke_addr = '0;
  logic [63:0] poke_data = '0;
  logic        tamper_en = 1'b0;
  logic        tamper_used = 1'b0;

  // captured results of the last walk
  logic        r_fault, r_r, r_w, r_x;
  logic [55:0] r_pa;
  int          r_reads, r_cas;

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FA = 8'h40, FD = 8'h80;
  localparam logic [43:0] L1P = 44'h200, L0P = 44'h300, ROP = 44'h1000_0300, DP = 44'h12345;
  localparam logic [38:0] VA = (39'd1 << 30) | (39'd2 << 21) | (39'd3 << 12) | 39'habc;

  always #5 clk = ~clk;

  pt_walker u0 (.*);

  // behavioural memory: bit 40 of the address marks a non-updatable region
  always @(posedge clk) begin
    logic [63:0] old;
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= ~mem_req_ready;
    if (!tamper_en) tamper_used <= 1'b0;
    if (poke_en) mem[poke_addr] = poke_data;
    if (mem_req_valid && mem_req_ready) begin
      old = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
      if (mem_req_cas) begin
        if (tamper_en && !tamper_used) begin
          old = old | 64'h100;
          tamper_used <= 1'b1;
        end
        mem[mem_req_addr] = (old == mem_req_cmp) ? mem_req_swap : old;
        cas_total <= cas_total + 1;
      end else begin
        rd_total <= rd_total + 1;
      end
      mem_rsp_data  <= old;
      mem_rsp_ro    <= mem_req_addr[40];
      mem_rsp_valid <= 1'b1;
    end
  end

  function automatic logic [63:0] mkpte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'd0, ppn, 2'b00, fl};
  endfunction

  function automatic logic [55:0] slot(input logic [43:0] tbl, input int idx);
    return {tbl, 12'h000} + 56'(idx * 8);
  endfunction

  function automatic logic [63:0] peek(input logic [55:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [55:0] a, input logic [63:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic build3(input logic [43:0] l0, input logic [63:0] leaf);
    poke(slot(root_ppn, 1), mkpte(L1P, FV));
    poke(slot(L1P, 2), mkpte(l0, FV));
    poke(slot(l0, 3), leaf);
  endtask

  task automatic run(input logic [1:0] acc, input logic ps, input logic su, input logic mx);
    int rd0, cs0, n;
    rd0 = rd_total; cs0 = cas_total;
    @(negedge clk);
    chk("R1 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_va = VA; req_acc = acc;
    req_priv_s = ps; req_sum = su; req_mxr = mx;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk("R13 walk completes", 64'(done), 64'd1);
    r_fault = done_fault; r_pa = done_pa; r_r = done_r; r_w = done_w; r_x = done_x;
    @(negedge clk);
    chk("R13 done one cycle", 64'(done), 64'd0);
    r_reads = rd_total - rd0;
    r_cas = cas_total - cs0;
  endtask

  task automatic expect_fault(input string tag);
    chk(tag, 64'(r_fault), 64'd1);
    chk({tag, " perms cleared R9"}, {61'd0, r_r, r_w, r_x}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    chk("R1 reset no mem req", 64'(mem_req_valid), 64'd0);
    chk("R1 reset no done", 64'(done), 64'd0);
  endtask

  task automatic t_load_4k;
    build3(L0P, mkpte(DP, FV | FR | FW | FA | FD));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    chk("R2 4k pa", 64'(r_pa), 64'({DP, 12'h000} | 56'(VA[11:0])));
    chk("R2 three reads", 64'(r_reads), 64'd3);
    chk("R9 perms rwx", {61'd0, r_r, r_w, r_x}, 64'b110);
    chk("R10 no swap when unchanged", 64'(r_cas), 64'd0);
  endtask

  task automatic t_ad_update;
    build3(L0P, mkpte(DP, FV | FR | FW));
    run(2'd1, 1'b1, 1'b0, 1'b0);
    chk("R10 store ok", 64'(r_fault), 64'd0);
    chk("R10 store one swap", 64'(r_cas), 64'd1);
    chk("R10 store sets A D", peek(slot(L0P, 3)), mkpte(DP, FV | FR | FW | FA | FD));
    chk("R9 store grants w", 64'(r_w), 64'd1);
    build3(L0P, mkpte(DP, FV | FR | FW));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    chk("R10 load sets A only", peek(slot(L0P, 3)), mkpte(DP, FV | FR | FW | FA));
    chk("R9 clean load no w", 64'(r_w), 64'd0);
  endtask

  task automatic t_invalid;
    poke(slot(root_ppn, 1), mkpte(L1P, FV));
    poke(slot(L1P, 2), 64'h0);
    run(2'd0, 1'b1, 1'b0, 1'b0);
    expect_fault("R3 invalid entry");
    chk("R3 stops after two reads", 64'(r_reads), 64'd2);
    build3(L0P, mkpte(DP, FV));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    expect_fault("R3 pointer at last level");
  endtask

  task automatic t_reserved;
    build3(L0P, mkpte(DP, FV | FW | FA | FD));
    run(2'd1, 1'b1, 1'b0, 1'b0);
    expect_fault("R4 W only");
    build3(L0P, mkpte(DP, FV | FW | FX | FA | FD));
    run(2'd2, 1'b1, 1'b0, 1'b0);
    expect_fault("R4 W plus X");
  endtask

  task automatic t_user_pages;
    build3(L0P, mkpte(DP, FV | FR | FX | FU | FA));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    expect_fault("R5 sup load user page no sum");
    run(2'd0, 1'b1, 1'b1, 1'b0);
    chk("R5 sup load user page sum", 64'(r_fault), 64'd0);
    run(2'd2, 1'b1, 1'b1, 1'b0);
    expect_fault("R5 sup fetch user page");
    run(2'd2, 1'b0, 1'b0, 1'b0);
    chk("R5 user fetch user page", 64'(r_fault), 64'd0);
    build3(L0P, mkpte(DP, FV | FR | FA));
    run(2'd0, 1'b0, 1'b0, 1'b0);
    expect_fault("R6 user on sup page");
  endtask

  task automatic t_superpages;
    poke(slot(root_ppn, 1), mkpte(L1P, FV));
    poke(slot(L1P, 2), mkpte(44'h12400, FV | FR | FA));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    chk("R7 2M pa", 64'(r_pa), 64'({44'h12400, 12'h000} | (56'(VA) & 56'h1F_FFFF)));
    chk("R7 2M two reads", 64'(r_reads), 64'd2);
    poke(slot(L1P, 2), mkpte(44'h12401, FV | FR | FA));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    expect_fault("R7 misaligned 2M");
    poke(slot(root_ppn, 1), mkpte(44'h40000, FV | FR | FA));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    chk("R7 1G pa", 64'(r_pa), 64'({44'h40000, 12'h000} | (56'(VA) & 56'h3FFF_FFFF)));
  endtask

  task automatic t_access;
    build3(L0P, mkpte(DP, FV | FX | FA));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    expect_fault("R8 load exec-only no mxr");
    run(2'd0, 1'b1, 1'b0, 1'b1);
    chk("R8 load exec-only mxr", 64'(r_fault), 64'd0);
    chk("R9 mxr read perm", {61'd0, r_r, r_w, r_x}, 64'b101);
    build3(L0P, mkpte(DP, FV | FR | FA));
    run(2'd1, 1'b1, 1'b0, 1'b0);
    expect_fault("R8 store read-only");
    run(2'd2, 1'b1, 1'b0, 1'b0);
    expect_fault("R8 fetch no X");
    run(2'd3, 1'b1, 1'b0, 1'b0);
    expect_fault("R8 reserved access code");
  endtask

  task automatic t_ro_region;
    build3(ROP, mkpte(DP, FV | FR | FW));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    expect_fault("R12 update needed in ro region");
    chk("R12 no swap issued", 64'(r_cas), 64'd0);
    build3(ROP, mkpte(DP, FV | FR | FA));
    run(2'd0, 1'b1, 1'b0, 1'b0);
    chk("R12 ro region no update ok", 64'(r_fault), 64'd0);
  endtask

  task automatic t_cas_race;
    build3(L0P, mkpte(DP, FV | FR | FW));
    tamper_en = 1'b1;
    run(2'd1, 1'b1, 1'b0, 1'b0);
    tamper_en = 1'b0;
    chk("R11 race still succeeds", 64'(r_fault), 64'd0);
    chk("R11 restart rereads from root", 64'(r_reads), 64'd6);
    chk("R11 two swaps", 64'(r_cas), 64'd2);
    chk("R11 final entry", peek(slot(L0P, 3)), mkpte(DP, FV | FR | FW | FA | FD) | 64'h100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_load_4k;
    t_ad_update;
    t_invalid;
    t_reserved;
    t_user_pages;
    t_superpages;
    t_access;
    t_ro_region;
    t_cas_race;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule